// File: doc/BRIEF.md
# Multiplicative Frequency Boost Governor

This block holds a frequency boost value for one activity-monitor channel and updates it each time the monitor reports that the activity has stayed above or below its thresholds for several sampling periods in a row. A report of sustained high activity multiplies the boost by a large percentage and adds a fixed increment. A report of sustained low activity multiplies it by a small percentage. After each update the block decides which of the two consecutive-threshold reports the monitor should keep raising, and it recomputes a target frequency from the averaged activity count, the sampling period and the channel's upper threshold.

All divisions share one bit-serial divider, so an update takes a fixed number of cycles. While a computation is in progress, `busy` is high and new reports are dropped. `done` pulses for one cycle when `target` holds its new value. A `start` pulse restarts the channel at any time: it clears the boost, arms only the rising report, and recomputes the target.

Top module: `boost_governor`

## Requirements
- R1: After reset, `boost`, `target`, `arm_above`, `arm_below`, `busy` and `done` are all 0.
- R2: A `start` pulse sets `boost` to 0, sets `arm_above` to 1 and clears `arm_below`. It then recomputes `target` and pulses `done` 3*(FW+CW+1) clock edges after the edge that sampled `start`.
- R3: When `up_evt` is accepted, the new boost is min(boost*up_coeff/100, 2^FW-1) + 16000 (integer division), and `arm_below` is set to 1.
- R4: If the boost that R3 produces is greater than or equal to `max_freq`, `boost` becomes `max_freq` and `arm_above` is cleared to 0.
- R5: When `dn_evt` is accepted on its own, the new boost is min(boost*dn_coeff/100, 2^FW-1), and `arm_above` is set to 1.
- R6: If the boost that R5 produces is below 8000 (half the increment), `boost` becomes 0 and `arm_below` is cleared to 0.
- R7: When `up_evt` and `dn_evt` are both high at the accepting edge, only the R3/R4 update takes place.
- R8: Every percentage product divided by 100 saturates at 2^FW-1 (all ones) before any further use.
- R9: `target` = min(P + boost, 2^FW-1), where P = min(((avg_count/period_ms) * (10000/up_thresh))/100, 2^FW-1) and every division is an integer division.
- R10: An event accepted at a clock edge produces `done` high exactly 4*(FW+CW+1) edges later. `done` is a one-cycle pulse, and `boost` and the arm bits are updated before `done` rises.
- R11: `up_evt` and `dn_evt` are ignored while `busy` is high: such a pulse changes neither the result nor the end of the computation, and `busy` stays low after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse: clear boost, re-arm, recompute target |
| up_evt | input | 1 | Sustained-high-activity report |
| dn_evt | input | 1 | Sustained-low-activity report |
| avg_count | input | FW | Averaged activity count from the monitor |
| period_ms | input | PW | Sampling period in ms, nonzero |
| max_freq | input | FW | Boost ceiling |
| up_coeff | input | CW | Up-scaling percentage |
| dn_coeff | input | CW | Down-scaling percentage |
| up_thresh | input | TW | Upper threshold percentage, nonzero |
| boost | output | FW | Current boost value |
| target | output | FW | Computed target frequency |
| arm_above | output | 1 | Keep the rising consecutive report enabled |
| arm_below | output | 1 | Keep the falling consecutive report enabled |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: target updated |

## Verification
With the default widths, the serial divider takes 49 edges per quotient. An event therefore yields `done` 196 edges after the accepting edge, and a restart yields `done` 147 edges after the edge that sampled `start`. The bench drives inputs and samples outputs on falling edges and counts rising edges until `done` appears. It compares that count with these figures and checks `boost`, the arm bits and `target` only in that cycle. For the dropped-event case, the bench injects a stray report in the middle of a computation. It then confirms that the latency and the result are unchanged and that `busy` stays low for several cycles afterward.

// File: rtl/bgov_pkg.sv
package bgov_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_BOOST,
      PH_RATE,
      PH_COEF,
      PH_TGT
   } phase_e;

   localparam int PCT_BASE   = 100;
   localparam int SCALE_BASE = 10000;
endpackage

// File: rtl/bgov_div.sv
module bgov_div #(
   parameter int NW = 48,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] dividend,
   input  logic [DW-1:0] divisor,
   output logic [NW-1:0] quo,
   output logic          busy,
   output logic          valid
);
   localparam int CNTW = $clog2(NW + 1);

   logic [DW-1:0]   rem;
   logic [DW-1:0]   den;
   logic [NW-1:0]   q;
   logic [CNTW-1:0] cnt;
   logic            run;
   logic [DW:0]     trial;
   logic            ge;
   logic [DW:0]     rem_n;

   always_comb begin
      trial = {rem, q[NW-1]};
      ge    = trial >= {1'b0, den};
      rem_n = ge ? trial - {1'b0, den} : trial;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         den   <= '0;
         q     <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         valid <= 1'b0;
      end else if (go) begin
         rem   <= '0;
         den   <= divisor;
         q     <= dividend;
         cnt   <= CNTW'(NW);
         run   <= 1'b1;
         valid <= 1'b0;
      end else if (run) begin
         rem   <= rem_n[DW-1:0];
         q     <= {q[NW-2:0], ge};
         cnt   <= cnt - 1'b1;
         run   <= (cnt != CNTW'(1));
         valid <= (cnt == CNTW'(1));
      end else begin
         valid <= 1'b0;
      end
   end

   assign quo  = q;
   assign busy = run;

   p_div_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   p_div_go_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (busy && !valid));
endmodule

// File: rtl/bgov_step.sv
module bgov_step #(
   parameter int FW   = 32,
   parameter int STEP = 16000
) (
   input  logic          dir_up,
   input  logic [FW-1:0] scaled,
   input  logic [FW-1:0] max_freq,
   input  logic          above_i,
   input  logic          below_i,
   output logic [FW-1:0] boost_o,
   output logic          above_o,
   output logic          below_o
);
   localparam logic [FW:0]   STEP_W = (FW+1)'(STEP);
   localparam logic [FW-1:0] HALF   = FW'(STEP / 2);

   logic [FW:0] raised;

   always_comb begin
      raised  = {1'b0, scaled} + STEP_W;
      boost_o = scaled;
      above_o = above_i;
      below_o = below_i;
      if (dir_up) begin
         below_o = 1'b1;
         if (raised >= {1'b0, max_freq}) begin
            boost_o = max_freq;
            above_o = 1'b0;
         end else begin
            boost_o = raised[FW-1:0];
         end
      end else begin
         above_o = 1'b1;
         if (scaled < HALF) begin
            boost_o = '0;
            below_o = 1'b0;
         end
      end
   end
endmodule

// File: rtl/boost_governor.sv
module boost_governor
   import bgov_pkg::*;
#(
   parameter int FW      = 32,
   parameter int CW      = 16,
   parameter int PW      = 9,
   parameter int TW      = 8,
   parameter int STEP    = 16000,
   parameter bit SUM_SAT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          up_evt,
   input  logic          dn_evt,
   input  logic [FW-1:0] avg_count,
   input  logic [PW-1:0] period_ms,
   input  logic [FW-1:0] max_freq,
   input  logic [CW-1:0] up_coeff,
   input  logic [CW-1:0] dn_coeff,
   input  logic [TW-1:0] up_thresh,
   output logic [FW-1:0] boost,
   output logic [FW-1:0] target,
   output logic          arm_above,
   output logic          arm_below,
   output logic          busy,
   output logic          done
);
   localparam int NW = FW + CW;
   localparam int DW = CW;

   generate
      if (CW < 14) begin : g_bad_cw
         $error("CW must hold the value 10000");
      end
      if (PW > CW || TW > CW) begin : g_bad_div
         $error("divisor inputs wider than CW");
      end
      if (FW < 16) begin : g_bad_fw
         $error("FW too narrow for the step");
      end
   endgenerate

   phase_e        state;
   logic          dir_up;
   logic [FW-1:0] rate_r;

   logic          div_go;
   logic [NW-1:0] div_num;
   logic [DW-1:0] div_den;
   logic [NW-1:0] div_q;
   logic          div_busy;
   logic          div_valid;
   logic [CW-1:0] coef_sel;
   logic [FW-1:0] q_sat;
   logic [FW-1:0] step_boost;
   logic          step_above;
   logic          step_below;
   logic [FW-1:0] sum_out;

   assign coef_sel = up_evt ? up_coeff : dn_coeff;
   assign q_sat    = (|div_q[NW-1:FW]) ? '1 : div_q[FW-1:0];

   always_comb begin
      div_go  = 1'b0;
      div_num = '0;
      div_den = '0;
      if (start) begin
         div_go  = 1'b1;
         div_num = NW'(avg_count);
         div_den = DW'(period_ms);
      end else begin
         case (state)
            PH_IDLE: if (up_evt || dn_evt) begin
               div_go  = 1'b1;
               div_num = NW'(boost) * NW'(coef_sel);
               div_den = DW'(PCT_BASE);
            end
            PH_BOOST: if (div_valid) begin
               div_go  = 1'b1;
               div_num = NW'(avg_count);
               div_den = DW'(period_ms);
            end
            PH_RATE: if (div_valid) begin
               div_go  = 1'b1;
               div_num = NW'(SCALE_BASE);
               div_den = DW'(up_thresh);
            end
            PH_COEF: if (div_valid) begin
               div_go  = 1'b1;
               div_num = NW'(rate_r) * NW'(div_q[CW-1:0]);
               div_den = DW'(PCT_BASE);
            end
            default: ;
         endcase
      end
   end

   bgov_div #(.NW(NW), .DW(DW)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (div_go),
      .dividend (div_num),
      .divisor  (div_den),
      .quo      (div_q),
      .busy     (div_busy),
      .valid    (div_valid)
   );

   bgov_step #(.FW(FW), .STEP(STEP)) i_step (
      .dir_up   (dir_up),
      .scaled   (q_sat),
      .max_freq (max_freq),
      .above_i  (arm_above),
      .below_i  (arm_below),
      .boost_o  (step_boost),
      .above_o  (step_above),
      .below_o  (step_below)
   );

   generate
      if (SUM_SAT) begin : g_sum_sat
         logic [FW:0] wide;
         assign wide    = {1'b0, q_sat} + {1'b0, boost};
         assign sum_out = wide[FW] ? '1 : wide[FW-1:0];
      end else begin : g_sum_wrap
         assign sum_out = q_sat + boost;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PH_IDLE;
         dir_up    <= 1'b0;
         rate_r    <= '0;
         boost     <= '0;
         target    <= '0;
         arm_above <= 1'b0;
         arm_below <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            boost     <= '0;
            arm_above <= 1'b1;
            arm_below <= 1'b0;
            state     <= PH_RATE;
         end else begin
            case (state)
               PH_IDLE: if (up_evt || dn_evt) begin
                  dir_up <= up_evt;
                  state  <= PH_BOOST;
               end
               PH_BOOST: if (div_valid) begin
                  boost     <= step_boost;
                  arm_above <= step_above;
                  arm_below <= step_below;
                  state     <= PH_RATE;
               end
               PH_RATE: if (div_valid) begin
                  rate_r <= div_q[FW-1:0];
                  state  <= PH_COEF;
               end
               PH_COEF: if (div_valid) begin
                  state <= PH_TGT;
               end
               PH_TGT: if (div_valid) begin
                  target <= sum_out;
                  done   <= 1'b1;
                  state  <= PH_IDLE;
               end
               default: state <= PH_IDLE;
            endcase
         end
      end
   end

   assign busy = (state != PH_IDLE);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (boost == '0 && arm_above && !arm_below));
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(boost));
   p_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_BOOST && div_valid && !start && dir_up) |=> (boost <= $past(max_freq)));
   p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_BOOST && div_valid && !start && !dir_up) |=> arm_above);
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/test_boost_governor.sv
`timescale 1ns/1ps
module test_boost_governor;
   localparam int FW = 32, CW = 16, PW = 9, TW = 8;
   localparam int NW = FW + CW;
   localparam int LAT_EVT = 4 * (NW + 1);
   localparam int LAT_START = 3 * (NW + 1);
   localparam longint unsigned ONES = 64'h0000_0000_FFFF_FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, up_evt = 1'b0, dn_evt = 1'b0;
   logic [FW-1:0] avg_count = '0;
   logic [PW-1:0] period_ms = 9'd12;
   logic [FW-1:0] max_freq = '0;
   logic [CW-1:0] up_coeff = '0, dn_coeff = '0;
   logic [TW-1:0] up_thresh = 8'd60;
   logic [FW-1:0] boost, target;
   logic arm_above, arm_below, busy, done;

   int errors = 0;
   int checks = 0;
   longint unsigned mb;
   bit ma, mbl;

   always #2.5 clk = ~clk;

   boost_governor #(.FW(FW), .CW(CW), .PW(PW), .TW(TW)) i_boost_governor (
      .clk(clk), .rst_n(rst_n), .start(start), .up_evt(up_evt), .dn_evt(dn_evt),
      .avg_count(avg_count), .period_ms(period_ms), .max_freq(max_freq),
      .up_coeff(up_coeff), .dn_coeff(dn_coeff), .up_thresh(up_thresh),
      .boost(boost), .target(target), .arm_above(arm_above), .arm_below(arm_below),
      .busy(busy), .done(done)
   );

   function automatic longint unsigned sat(input longint unsigned x);
      return (x > ONES) ? ONES : x;
   endfunction

   function automatic longint unsigned model_target();
      longint unsigned rate, c3, p;
      rate = longint'(avg_count) / longint'(period_ms);
      c3 = 64'd10000 / longint'(up_thresh);
      p = sat((rate * c3) / 100);
      return sat(p + mb);
   endfunction

   task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      chk({req, " boost"}, boost, mb);
      chk({req, " arm_above"}, arm_above, ma);
      chk({req, " arm_below"}, arm_below, mbl);
      chk({req, " target R9"}, target, model_target());
   endtask

   task automatic wait_done(input int exp_lat, input bit stray, input string req);
      int cyc = 0;
      while (!done && cyc < 1000) begin
         if (stray && cyc == 10) up_evt = 1'b1;
         if (stray && cyc == 11) up_evt = 1'b0;
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      chk({req, " latency R10"}, cyc, exp_lat);
      @(posedge clk);
      @(negedge clk);
      chk("R10 done pulse width", done, 0);
   endtask

   task automatic do_start();
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      mb = 0; ma = 1; mbl = 0;
      wait_done(LAT_START, 1'b0, "R2");
      check_state("R2");
   endtask

   task automatic do_evt(input bit u, input bit d, input bit stray, input string req);
      longint unsigned q, nb;
      up_evt = u;
      dn_evt = d;
      @(posedge clk);
      @(negedge clk);
      up_evt = 1'b0;
      dn_evt = 1'b0;
      if (u) begin
         q = sat((mb * longint'(up_coeff)) / 100);
         nb = q + 16000;
         mbl = 1;
         if (nb >= longint'(max_freq)) begin
            mb = longint'(max_freq);
            ma = 0;
         end else begin
            mb = nb;
         end
      end else begin
         q = sat((mb * longint'(dn_coeff)) / 100);
         ma = 1;
         if (q < 8000) begin
            mb = 0;
            mbl = 0;
         end else begin
            mb = q;
         end
      end
      wait_done(LAT_EVT, stray, req);
      check_state(req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      int cu[2];
      int cd[2];
      int th[2];
      int ths[4];
      int pers[3];
      logic [31:0] avgs[3];
      cu[0] = 200; cd[0] = 50; th[0] = 60;
      cu[1] = 800; cd[1] = 40; th[1] = 27;
      ths[0] = 10; ths[1] = 27; ths[2] = 60; ths[3] = 100;
      pers[0] = 1; pers[1] = 12; pers[2] = 256;
      avgs[0] = 32'd0; avgs[1] = 32'd12345678; avgs[2] = 32'hFFFF_FFFF;

      repeat (3) @(negedge clk);
      // R1: state held in reset and just after release
      chk("R1 boost", boost, 0);
      chk("R1 target", target, 0);
      chk("R1 arm_above", arm_above, 0);
      chk("R1 arm_below", arm_below, 0);
      chk("R1 busy", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done", done, 0);
      chk("R1 busy after release", busy, 0);

      // R3 R4 R5 R6: up ramp to the ceiling, then decay to zero
      max_freq = 32'd1000000;
      avg_count = 32'd6000000;
      period_ms = 9'd12;
      for (int p = 0; p < 2; p++) begin
         up_coeff = cu[p][CW-1:0];
         dn_coeff = cd[p][CW-1:0];
         up_thresh = th[p][TW-1:0];
         do_start();
         for (int k = 0; k < 8; k++) do_evt(1'b1, 1'b0, 1'b0, "R3 R4 up");
         for (int k = 0; k < 10; k++) do_evt(1'b0, 1'b1, 1'b0, "R5 R6 down");
      end

      // R7: both reports together act as an up report
      do_evt(1'b1, 1'b0, 1'b0, "R3 pre");
      do_evt(1'b1, 1'b1, 1'b0, "R7 both");

      // R11: stray report during a computation is dropped
      do_evt(1'b0, 1'b1, 1'b1, "R11 stray");
      for (int k = 0; k < 4; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R11 busy stays low", busy, 0);
      end
      check_state("R11 after");

      // R8: saturation with an all-ones ceiling
      max_freq = 32'hFFFF_FFFF;
      up_coeff = 16'd800;
      dn_coeff = 16'd40;
      do_start();
      for (int k = 0; k < 10; k++) do_evt(1'b1, 1'b0, 1'b0, "R8 sat up");
      do_evt(1'b0, 1'b1, 1'b0, "R8 sat down");

      // R9: target sweep over averages, periods and thresholds
      for (int a = 0; a < 3; a++)
         for (int pi = 0; pi < 3; pi++)
            for (int t = 0; t < 4; t++) begin
               avg_count = avgs[a];
               period_ms = pers[pi][PW-1:0];
               up_thresh = ths[t][TW-1:0];
               do_start();
            end
      do_evt(1'b1, 1'b0, 1'b0, "R9 with boost");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule